// File: doc/BRIEF.md
# Split-Transaction Ordering Queue Arbiter

This block sits on one side of a bus bridge. It holds the transactions latched from that side and picks which one goes out next. Entries are sorted into three first-in-first-out class queues: posted memory writes, split requests (read or write), and split completions (read or write). Each entry holds a 3-bit kind code, a relaxed-ordering (RO) flag, a tag, and a global arrival sequence number that the block assigns when the entry is accepted.

On every cycle the block looks at the three queue heads. A head may issue only when its class's downstream ready is high. It must also be allowed to overtake every older entry that is still waiting in the other two queues. A head overtakes an older entry only when the pairing permits it and that older entry's class is stalled, meaning its ready is low. When several heads can go, the oldest one goes, so any reordering that is merely optional is never taken.

Because each class has its own ready input, a stalled class never holds back a class that is required to get past it. The chosen entry appears on registered outputs one cycle after the pick.

Top module: `stoq_arbiter`

## Requirements
- R1: Kind codes are 0 = posted write, 1 = split read request, 2 = split write request, 3 = split read completion and 4 = split write completion. Codes 0 to 4 go to the posted (class 0), request (class 1) and completion (class 2) queues. Codes 5 to 7 are ignored: nothing is stored and nothing is ever issued for them.
- R2: Each class queue holds DEPTH entries. Its bit in `q_full` (bit index = class) is high exactly when the queue holds DEPTH entries. An input offered to a full class is refused and not stored.
- R3: Within one class, entries leave in arrival order. The kind, RO flag and tag of an entry come out unchanged.
- R4: At most one entry issues per clock edge. An entry picked at an edge was the head of a class whose `out_rdy` bit was high before that edge. `out_valid` and the entry's fields are then presented from the next cycle on, for one cycle.
- R5: Whenever no stall-driven bypass applies, the oldest eligible head issues first.
- R6: A posted-write head issues ahead of older request or completion entries whose class ready is low.
- R7: A split request never issues while an older posted write is still queued.
- R8: A read completion with RO = 0 never issues while an older posted write is queued. A read completion with RO = 1 issues ahead of an older posted write when the posted class ready is low.
- R9: A read completion issues ahead of older split requests when the request class ready is low. A write completion never passes an older posted write or an older request.
- R10: While reset is high, and on the first cycle after it, `out_valid` is low and every queue is empty with `q_full` clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A transaction is offered this cycle |
| in_kind | input | 3 | Kind code of the offered transaction |
| in_ro | input | 1 | Relaxed-ordering flag of the offered transaction |
| in_tag | input | TAGW | Tag of the offered transaction |
| q_full | output | 3 | Per-class full flag (0 posted, 1 request, 2 completion) |
| out_rdy | input | 3 | Per-class downstream ready |
| out_valid | output | 1 | An entry was issued (registered) |
| out_kind | output | 3 | Kind code of the issued entry |
| out_ro | output | 1 | RO flag of the issued entry |
| out_tag | output | TAGW | Tag of the issued entry |

## Verification
Short directed sequences pin down each ordering rule. Each one places an older entry of one class in front of a newer entry of another class and holds only the newer class ready. This separates the forbidden pairs from the must-pass pairs and from the RO-gated pair. An all-ready drain separates arrival order from any reordering. Filling one class past its depth, and offering the codes 5 to 7, show that refused and unknown inputs leave no trace in the output stream. Long random phases then vary the kind mix and ready patterns (all ready, single class stalled, random), so that bypasses chain across all three queues while the block is compared each cycle against a queue-based reference model.

// File: rtl/stoq_pkg.sv
package stoq_pkg;

  localparam int NCLS = 3;

  localparam logic [1:0] CL_PST = 2'd0;
  localparam logic [1:0] CL_REQ = 2'd1;
  localparam logic [1:0] CL_CMP = 2'd2;

  localparam logic [2:0] K_PMW = 3'd0;
  localparam logic [2:0] K_SRR = 3'd1;
  localparam logic [2:0] K_SWR = 3'd2;
  localparam logic [2:0] K_SRC = 3'd3;
  localparam logic [2:0] K_SWC = 3'd4;

  function automatic logic kind_ok(input logic [2:0] k);
    return k <= K_SWC;
  endfunction

  function automatic logic [1:0] kind_cls(input logic [2:0] k);
    logic [1:0] c;
    case (k)
      K_PMW:        c = CL_PST;
      K_SRR, K_SWR: c = CL_REQ;
      default:      c = CL_CMP;
    endcase
    return c;
  endfunction

  function automatic logic [NCLS-1:0] cls_mask(input logic [2:0] k);
    return 3'b001 << kind_cls(k);
  endfunction

  // May a newer head of kind nk (RO flag nro) overtake an older entry of class oc
  // whose class is stalled? Optional pairs answer 0 to keep arrival order.
  function automatic logic may_bypass(input logic [2:0] nk, input logic nro,
                                      input logic [1:0] oc);
    logic r;
    case (oc)
      CL_PST:  r = (nk == K_SRC) && nro;
      CL_REQ:  r = (nk == K_PMW) || (nk == K_SRC);
      default: r = (nk == K_PMW);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/stoq_fifo.sv
module stoq_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0]   CAP  = (AW+1)'(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rdata = mem[rp];
  assign empty = (cnt == '0);
  assign full  = (cnt == CAP);

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R2
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R4

endmodule

// File: rtl/stoq_pick.sv
module stoq_pick
  import stoq_pkg::*;
#(
  parameter int SEQW = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NCLS-1:0]            have,
  input  logic [NCLS-1:0]            rdy,
  input  logic [NCLS-1:0]            ro,
  input  logic [NCLS-1:0][2:0]       kind,
  input  logic [NCLS-1:0][SEQW-1:0]  seq,
  output logic [NCLS-1:0]            grant
);

  // a is older than b when a - b wraps negative; live span is below half the range
  function automatic logic older(input logic [SEQW-1:0] a, input logic [SEQW-1:0] b);
    logic [SEQW-1:0] d;
    d = a - b;
    return d[SEQW-1];
  endfunction

  logic [NCLS-1:0] elig;

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      elig[c] = have[c] && rdy[c];
      for (int o = 0; o < NCLS; o++) begin
        if (o != c && have[o] && older(seq[o], seq[c]) &&
            !(may_bypass(kind[c], ro[c], 2'(o)) && !rdy[o]))
          elig[c] = 1'b0;
      end
    end
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++) begin
      grant[c] = elig[c];
      for (int o = 0; o < NCLS; o++) begin
        if (o != c && elig[o] && older(seq[o], seq[c])) grant[c] = 1'b0;
      end
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R4
  AST_REQ_BEHIND_PMW: assert property (@(posedge clk) disable iff (rst)
    (grant[CL_REQ] && have[CL_PST]) |-> !older(seq[CL_PST], seq[CL_REQ])); // R7
  AST_CMP_OVER_PMW: assert property (@(posedge clk) disable iff (rst)
    (grant[CL_CMP] && have[CL_PST] && older(seq[CL_PST], seq[CL_CMP]))
      |-> (kind[CL_CMP] == K_SRC && ro[CL_CMP] && !rdy[CL_PST])); // R8

endmodule

// File: rtl/stoq_arbiter.sv
module stoq_arbiter
  import stoq_pkg::*;
#(
  parameter int TAGW  = 8,
  parameter int DEPTH = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [2:0]      in_kind,
  input  logic            in_ro,
  input  logic [TAGW-1:0] in_tag,
  output logic [2:0]      q_full,
  input  logic [2:0]      out_rdy,
  output logic            out_valid,
  output logic [2:0]      out_kind,
  output logic            out_ro,
  output logic [TAGW-1:0] out_tag
);

  localparam int SEQW = $clog2(NCLS * DEPTH) + 2;
  localparam int PW   = 3 + 1 + TAGW;
  localparam int EW   = PW + SEQW;

  logic [1:0]                in_cls;
  logic                      accept;
  logic [SEQW-1:0]           seq_ctr;
  logic [NCLS-1:0]           q_empty, q_have, grant;
  logic [NCLS-1:0][EW-1:0]   head;
  logic [NCLS-1:0][2:0]      h_kind;
  logic [NCLS-1:0]           h_ro;
  logic [NCLS-1:0][SEQW-1:0] h_seq;
  logic [PW-1:0]             sel;

  assign in_cls = kind_cls(in_kind);
  assign accept = in_valid && kind_ok(in_kind) && !q_full[in_cls];

  always_ff @(posedge clk) begin
    if (rst)         seq_ctr <= '0;
    else if (accept) seq_ctr <= seq_ctr + 1'b1;
  end

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    stoq_fifo #(.W(EW), .DEPTH(DEPTH)) i_q (
      .clk   (clk),
      .rst   (rst),
      .push  (accept && (in_cls == 2'(c))),
      .wdata ({in_kind, in_ro, in_tag, seq_ctr}),
      .pop   (grant[c]),
      .rdata (head[c]),
      .empty (q_empty[c]),
      .full  (q_full[c])
    );
    assign q_have[c] = !q_empty[c];
    assign h_kind[c] = head[c][EW-1 -: 3];
    assign h_ro[c]   = head[c][EW-4];
    assign h_seq[c]  = head[c][SEQW-1:0];
  end

  stoq_pick #(.SEQW(SEQW)) i_pick (
    .clk   (clk),
    .rst   (rst),
    .have  (q_have),
    .rdy   (out_rdy),
    .ro    (h_ro),
    .kind  (h_kind),
    .seq   (h_seq),
    .grant (grant)
  );

  always_comb begin
    sel = '0;
    for (int c = 0; c < NCLS; c++) begin
      if (grant[c]) sel = head[c][EW-1:SEQW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_kind  <= '0;
      out_ro    <= 1'b0;
      out_tag   <= '0;
    end else begin
      out_valid <= |grant;
      if (|grant) {out_kind, out_ro, out_tag} <= sel;
    end
  end

  AST_ISSUE_READY: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (($past(out_rdy) & cls_mask(out_kind)) != 3'b000)); // R4
  AST_ISSUE_KNOWN_KIND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> kind_ok(out_kind)); // R1
  AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && q_full == 3'b000)); // R10

endmodule

// File: tb/test_stoq_arbiter.sv
`timescale 1ns/1ps
module test_stoq_arbiter;

  localparam int TW = 8;
  localparam int DP = 8;

  typedef struct {
    logic [2:0]    k;
    bit            ro;
    logic [TW-1:0] t;
    int            s;
  } ent_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [2:0]    in_kind = '0;
  logic          in_ro = 1'b0;
  logic [TW-1:0] in_tag = '0;
  logic [2:0]    q_full;
  logic [2:0]    out_rdy = '0;
  logic          out_valid;
  logic [2:0]    out_kind;
  logic          out_ro;
  logic [TW-1:0] out_tag;

  always #2 clk = ~clk;

  stoq_arbiter #(.TAGW(TW), .DEPTH(DP)) i_stoq_arbiter (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_kind(in_kind), .in_ro(in_ro),
    .in_tag(in_tag), .q_full(q_full), .out_rdy(out_rdy), .out_valid(out_valid),
    .out_kind(out_kind), .out_ro(out_ro), .out_tag(out_tag)
  );

  ent_t          mq[3][$];
  int            nseq = 0;
  int            nchk = 0;
  int            nbad = 0;
  bit            done = 0;
  bit            ev = 0;
  logic [2:0]    ek = '0;
  bit            ero = 0;
  logic [TW-1:0] et = '0;
  string         cur_tag = "R10";

  function automatic int cls_of(logic [2:0] k);
    if (k == 3'd0) return 0;
    if (k == 3'd1 || k == 3'd2) return 1;
    return 2;
  endfunction

  // newer kind nk may overtake a stalled older class oc
  function automatic bit may_pass(logic [2:0] nk, bit nro, int oc);
    if (oc == 0) return (nk == 3'd3) && nro;
    if (nk == 3'd0) return 1;
    if (oc == 1 && nk == 3'd3) return 1;
    return 0;
  endfunction

  task automatic compare();
    logic [2:0] fx;
    fx = {mq[2].size() == DP, mq[1].size() == DP, mq[0].size() == DP};
    nchk++;
    if (out_valid !== ev || (ev && (out_kind !== ek || out_ro !== ero || out_tag !== et))) begin
      nbad++;
      $display("FAIL %s: out v=%0b k=%0d ro=%0b tag=%0d, expected v=%0b k=%0d ro=%0b tag=%0d",
               cur_tag, out_valid, out_kind, out_ro, out_tag, ev, ek, ero, et);
    end
    nchk++;
    if (q_full !== fx) begin
      nbad++;
      $display("FAIL R2: q_full=%b expected %b", q_full, fx);
    end
  endtask

  task automatic model_step(bit v, logic [2:0] k, bit ro, logic [TW-1:0] t, logic [2:0] r);
    int   best;
    bit   acc;
    ent_t h;
    ent_t n;
    bit   ok;
    best = -1;
    acc  = v && (k <= 3'd4) && (mq[cls_of(k)].size() < DP);
    for (int c = 0; c < 3; c++) begin
      if (r[c] && mq[c].size() > 0) begin
        h  = mq[c][0];
        ok = 1;
        for (int o = 0; o < 3; o++) begin
          if (o != c) begin
            for (int i = 0; i < mq[o].size(); i++) begin
              if (mq[o][i].s < h.s && !(may_pass(h.k, h.ro, o) && !r[o])) ok = 0;
            end
          end
        end
        if (ok && (best < 0 || h.s < mq[best][0].s)) best = c;
      end
    end
    ev = (best >= 0);
    if (ev) begin
      h   = mq[best].pop_front();
      ek  = h.k;
      ero = h.ro;
      et  = h.t;
    end
    if (acc) begin
      n.k = k; n.ro = ro; n.t = t; n.s = nseq;
      nseq++;
      mq[cls_of(k)].push_back(n);
    end
  endtask

  task automatic cyc(bit v, logic [2:0] k, bit ro, logic [TW-1:0] t, logic [2:0] r);
    @(negedge clk);
    compare();
    in_valid = v; in_kind = k; in_ro = ro; in_tag = t; out_rdy = r;
    model_step(v, k, ro, t, r);
  endtask

  task automatic idle(int n, logic [2:0] r);
    for (int i = 0; i < n; i++) cyc(0, 3'd0, 0, '0, r);
  endtask

  task automatic rnd_phase(int n, int mode);
    logic [2:0] r;
    logic [2:0] k;
    for (int i = 0; i < n; i++) begin
      case (mode)
        0: r = 3'b111;
        1: r = ($urandom_range(0, 3) == 0) ? 3'b111 : 3'b110;
        2: r = ($urandom_range(0, 1) == 0) ? 3'b101 : 3'b011;
        default: r = 3'($urandom_range(0, 7));
      endcase
      k = ($urandom_range(0, 9) == 0) ? 3'($urandom_range(5, 7)) : 3'($urandom_range(0, 4));
      cyc($urandom_range(0, 9) < 7, k, 1'($urandom_range(0, 1)), TW'($urandom_range(0, 255)), r);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    ev  = 0;
    // R10: reset state observed on the first compares
    cur_tag = "R10";
    idle(2, 3'b111);
    // R1: unknown kinds leave nothing behind
    cur_tag = "R1";
    cyc(1, 3'd5, 0, 8'd1, 3'b000);
    cyc(1, 3'd7, 1, 8'd2, 3'b000);
    cyc(1, 3'd6, 0, 8'd3, 3'b000);
    idle(4, 3'b111);
    // R2: overfill the posted queue, one is refused; R3: FIFO drain
    cur_tag = "R2";
    for (int i = 0; i < DP + 1; i++) cyc(1, 3'd0, i[0], TW'(20 + i), 3'b000);
    idle(2, 3'b000);
    cur_tag = "R3";
    idle(DP + 3, 3'b111);
    // R7: request stays behind an older posted write
    cur_tag = "R7";
    cyc(1, 3'd0, 0, 8'd40, 3'b000);
    cyc(1, 3'd1, 1, 8'd41, 3'b000);
    cyc(1, 3'd2, 0, 8'd42, 3'b000);
    idle(4, 3'b010);
    idle(4, 3'b111);
    // R8: read completion over a stalled posted write only with RO set
    cur_tag = "R8";
    cyc(1, 3'd0, 0, 8'd50, 3'b000);
    cyc(1, 3'd3, 0, 8'd51, 3'b000);
    idle(4, 3'b100);
    idle(3, 3'b111);
    cyc(1, 3'd0, 0, 8'd52, 3'b000);
    cyc(1, 3'd3, 1, 8'd53, 3'b000);
    idle(3, 3'b100);
    idle(3, 3'b111);
    // R9: read completion over stalled requests; write completion never passes
    cur_tag = "R9";
    cyc(1, 3'd1, 0, 8'd60, 3'b000);
    cyc(1, 3'd3, 0, 8'd61, 3'b000);
    cyc(1, 3'd4, 0, 8'd62, 3'b000);
    idle(4, 3'b100);
    idle(3, 3'b111);
    cyc(1, 3'd0, 0, 8'd63, 3'b000);
    cyc(1, 3'd4, 1, 8'd64, 3'b000);
    idle(4, 3'b100);
    idle(3, 3'b111);
    // R6: posted write passes stalled requests and completions
    cur_tag = "R6";
    cyc(1, 3'd1, 0, 8'd70, 3'b000);
    cyc(1, 3'd3, 0, 8'd71, 3'b000);
    cyc(1, 3'd0, 0, 8'd72, 3'b000);
    idle(3, 3'b001);
    idle(3, 3'b111);
    // R5: all ready, arrival order kept
    cur_tag = "R5";
    cyc(1, 3'd3, 1, 8'd80, 3'b000);
    cyc(1, 3'd2, 0, 8'd81, 3'b000);
    cyc(1, 3'd0, 1, 8'd82, 3'b000);
    cyc(1, 3'd4, 0, 8'd83, 3'b000);
    idle(6, 3'b111);
    // random phases
    cur_tag = "R5"; rnd_phase(1500, 0);
    cur_tag = "R6"; rnd_phase(1500, 1);
    cur_tag = "R9"; rnd_phase(1500, 2);
    cur_tag = "R4"; rnd_phase(3000, 3);
    cur_tag = "R3"; idle(40, 3'b111);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nbad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
      $finish;
    end
  end

endmodule